// File: doc/BRIEF.md
# PHY Management Bridge with Link Model

This block gives a host a small register window onto an embedded model of an Ethernet PHY's management registers. The host writes a command register that names a PHY address, a register index and a direction. One cycle later the block carries out the access. A read loads the result into a data register. A write copies the low half of the data register into the addressed PHY register. A busy flag in the command register drops when the access has finished, so the host can poll it.

The block also models the link. A `link_present` input stands for the cable or partner being there. When the link drops, the block clears the PHY's link and negotiation state. When the link returns, the block either raises the link at once, or it first runs a timed auto-negotiation countdown whose length is a cycle-count parameter. Each link change sets a bit in an interrupt status register. A mask register gates that status onto a level interrupt pin, and a `link_up` pin gives the adapter's view of the link.

Top module: `mgmt_phy_bridge`

## Requirements
- R1: Out of reset the six PHY registers hold these values: control (index 0) 0x1100, with full duplex at bit 8 and auto-negotiation enable at bit 12. Status (index 1) 0x002C, with link at bit 2, negotiation ability at bit 3 and negotiation complete at bit 5. Indices 2 and 3 hold 0. Advertisement (4) and partner (5) both hold 0x03E0, which is bits 5 to 9 for 10, 10 full duplex, 100TX, 100TX full duplex and T4. Out of reset `irq` is 0, `link_up` is 1, and the data register (word 4) reads 0.
- R2: A host write to word 3 stores a command with these fields: index in bits 4:0, PHY address in bits 9:5, write flag in bit 10, busy in bit 15. The access happens on the next clock edge. With bit 10 clear, word 4 becomes the zero-extended register value. With bit 10 set, word 4 bits 15:0 are written into the PHY register.
- R3: Busy (word 3 bit 15) reads back as written until the access edge, and reads 0 afterwards.
- R4: Only PHY address PHY_ADDR (default 1) responds. A read addressed to any other PHY sets word 4 to 0xFFFFFFFF, and a write to another PHY changes no register.
- R5: A register index of 6 or more reads as 0, and a write to such an index changes nothing.
- R6: One edge after `link_present` falls, the status register loses link and negotiation complete, the partner register loses its acknowledge bit (bit 14), `link_up` goes to 0, and interrupt status bit 4 is set.
- R7: When `link_present` rises while auto-negotiation is enabled and not complete, `link_up` is still 0 AN_DELAY edges after the rise and is 1 one edge later. At that edge the status register gains link and negotiation complete, the partner register gains acknowledge, and interrupt status bit 4 is set.
- R8: When `link_present` rises and auto-negotiation is disabled or already complete, one edge later the link bit in the status register and `link_up` are set, and so is interrupt status bit 4.
- R9: If `link_present` falls during the countdown, the countdown is cancelled, and `link_up` stays 0 afterwards for as long as the link is absent.
- R10: Interrupt status (word 0) is write-one-to-clear, and the mask (word 1) is read-write. The `irq` pin equals the OR of status AND mask as it stands after each edge, so a mask or status write shows on `irq` one edge later. If a link event and a clear of the same bit fall on one edge, the event wins.
- R11: The MII status word (word 2) always reads 0, and writes to it have no visible effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| link_present | input | 1 | Physical link indication |
| irq | output | 1 | Level interrupt |
| link_up | output | 1 | Adapter link state |

## Verification
A host write lands on the edge it straddles, and a management access completes on the edge after that. The bench therefore reads word 4 at the falling edge that follows the completing edge. It reads word 3 once before and once after that edge to see the busy flag drop. Link-loss and immediate link-up results are due one edge after the input changes. The negotiation result is due AN_DELAY+1 edges after the rise, so the bench counts edges from the rise and samples on both sides of that boundary. Interrupt-pin effects of a mask or status write are due on the edge the write lands on, and the bench samples them at the next falling edge.

// File: rtl/mgmt_pkg.sv
// Package: shared constants for the PHY management bridge.
// Holds the host word map, the command field positions, the PHY bit positions
// and the reset values of the PHY register model.
package mgmt_pkg;

    localparam int HOST_AW   = 3;
    localparam int HOST_DW   = 32;
    localparam int MII_W     = 16;
    localparam int IDX_W     = 5;
    localparam int PHYA_W    = 5;

    // host word addresses
    localparam logic [HOST_AW-1:0] W_IRQ_STAT = 3'd0;
    localparam logic [HOST_AW-1:0] W_IRQ_MASK = 3'd1;
    localparam logic [HOST_AW-1:0] W_MII_STAT = 3'd2;
    localparam logic [HOST_AW-1:0] W_MGMT_CMD = 3'd3;
    localparam logic [HOST_AW-1:0] W_MGMT_DAT = 3'd4;
    localparam logic [HOST_AW-1:0] W_LINK_CTL = 3'd5;

    // command field positions
    localparam int CMD_PHY_LSB = 5;
    localparam int CMD_WR_BIT  = 10;
    localparam int CMD_BUSY    = 15;

    // interrupt status bit for link events
    localparam int IRQ_LINK_BIT = 4;

    // PHY register indices and bits
    localparam int PI_CTRL  = 0;
    localparam int PI_STAT  = 1;
    localparam int PI_ADV   = 4;
    localparam int PI_PART  = 5;
    localparam int CB_FDX   = 8;
    localparam int CB_ANEN  = 12;
    localparam int SB_LINK  = 2;
    localparam int SB_ANABL = 3;
    localparam int SB_ANDONE= 5;
    localparam int PB_ACK   = 14;
    localparam logic [MII_W-1:0] ABIL_MASK = 16'h03E0;

    // Reset value of PHY register idx.
    function automatic logic [MII_W-1:0] phy_reset_value(input int idx);
        logic [MII_W-1:0] v;
        v = '0;
        case (idx)
            PI_CTRL: begin v[CB_FDX] = 1'b1; v[CB_ANEN] = 1'b1; end
            PI_STAT: begin v[SB_LINK] = 1'b1; v[SB_ANABL] = 1'b1; v[SB_ANDONE] = 1'b1; end
            PI_ADV, PI_PART: v = ABIL_MASK;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/mgmt_phy_regs.sv
// Module: mgmt_phy_regs
// Register model of the embedded PHY. It holds NUM_REGS registers of MII_W
// bits each. It applies one host-initiated access per cycle, then applies the
// link events on top of it, so an event wins over a write in the same cycle.
// Assumes: events are single-cycle pulses, at most one of them per cycle.
module mgmt_phy_regs
    import mgmt_pkg::*;
#(
    parameter int NUM_REGS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             acc_wr,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [MII_W-1:0] acc_wdata,
    output logic [MII_W-1:0] acc_rdata,
    input  logic             ev_down,
    input  logic             ev_link_set,
    input  logic             ev_an_done,
    output logic             an_enable,
    output logic             an_complete
);

    localparam int FLAT_W = NUM_REGS * MII_W;

    logic [FLAT_W-1:0] regs_q;
    logic [MII_W-1:0]  clr_m [NUM_REGS];
    logic [MII_W-1:0]  set_m [NUM_REGS];

    // Per-register clear and set masks that the link events produce.
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            clr_m[i] = '0;
            set_m[i] = '0;
        end
        if (ev_down) begin
            clr_m[PI_STAT][SB_LINK]   = 1'b1;
            clr_m[PI_STAT][SB_ANDONE] = 1'b1;
            clr_m[PI_PART][PB_ACK]    = 1'b1;
        end
        if (ev_link_set || ev_an_done) begin
            set_m[PI_STAT][SB_LINK] = 1'b1;
        end
        if (ev_an_done) begin
            set_m[PI_STAT][SB_ANDONE] = 1'b1;
            set_m[PI_PART][PB_ACK]    = 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [MII_W-1:0] base;
            // Select host write data or the held value for this register.
            always_comb begin
                base = regs_q[g*MII_W +: MII_W];
                if (acc_en && acc_wr && acc_idx == IDX_W'(g)) base = acc_wdata;
            end
            // Register update: reset value, then access, then events.
            always_ff @(posedge clk) begin
                if (!rst_n) regs_q[g*MII_W +: MII_W] <= phy_reset_value(g);
                else        regs_q[g*MII_W +: MII_W] <= (base & ~clr_m[g]) | set_m[g];
            end
        end
    endgenerate

    // Read mux: indices past the model read as zero.
    always_comb begin
        acc_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (acc_idx == IDX_W'(i)) acc_rdata = regs_q[i*MII_W +: MII_W];
        end
    end

    assign an_enable   = regs_q[PI_CTRL*MII_W + CB_ANEN];
    assign an_complete = regs_q[PI_STAT*MII_W + SB_ANDONE];

    // R6: a link loss leaves the status link bit and the partner ack clear
    a_r6_down_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ev_down |=> (!regs_q[PI_STAT*MII_W + SB_LINK] && !regs_q[PI_PART*MII_W + PB_ACK]));

    // R7: completed negotiation leaves complete and ack set
    a_r7_an_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_an_done |=> (an_complete && regs_q[PI_PART*MII_W + PB_ACK]));

endmodule

// File: rtl/mgmt_link_ctrl.sv
// Module: mgmt_link_ctrl
// Tracks the link_present input and turns its edges into link events. A rise
// with negotiation enabled but not complete starts an AN_DELAY-cycle
// countdown. The countdown ends in a negotiation-done event if the link is
// still there, and a link loss cancels it. Holds the adapter link flag.
// Assumes: link_present is already synchronous to clk; AN_DELAY >= 1.
module mgmt_link_ctrl #(
    parameter int AN_DELAY = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_present,
    input  logic an_enable,
    input  logic an_complete,
    output logic ev_down,
    output logic ev_link_set,
    output logic ev_an_done,
    output logic link_up_o
);

    localparam int CW = $clog2(AN_DELAY + 1);
    localparam logic [CW-1:0] LOAD = CW'(AN_DELAY - 1);

    logic          link_q;
    logic          running_q;
    logic [CW-1:0] cnt_q;
    logic          rise, start;

    // Edge detection and event decode.
    always_comb begin
        rise        = !link_q && link_present;
        ev_down     = link_q && !link_present;
        start       = rise && an_enable && !an_complete;
        ev_link_set = rise && !start;
        ev_an_done  = running_q && (cnt_q == '0) && link_present;
    end

    // Previous link sample; reset assumes the link is present.
    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= 1'b1;
        else        link_q <= link_present;
    end

    // Negotiation countdown: load on start, cancel on loss, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running_q <= 1'b0;
            cnt_q     <= '0;
        end else if (ev_down) begin
            running_q <= 1'b0;
        end else if (start) begin
            running_q <= 1'b1;
            cnt_q     <= LOAD;
        end else if (running_q) begin
            if (cnt_q == '0) running_q <= 1'b0;
            else             cnt_q     <= cnt_q - 1'b1;
        end
    end

    // Adapter link flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                         link_up_o <= 1'b1;
        else if (ev_down)                   link_up_o <= 1'b0;
        else if (ev_link_set || ev_an_done) link_up_o <= 1'b1;
    end

    // R6: a link loss drops link_up on the next edge
    a_r6_link_drops: assert property (@(posedge clk) disable iff (!rst_n)
        ev_down |=> !link_up_o);

    // R7: the countdown never exceeds its load value
    a_r7_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        running_q |-> (cnt_q <= LOAD));

    // R9: with the link absent, no countdown is left running
    a_r9_cancelled: assert property (@(posedge clk) disable iff (!rst_n)
        ev_down |=> !running_q);

endmodule

// File: rtl/mgmt_irq_ctrl.sv
// Module: mgmt_irq_ctrl
// Interrupt status (write-one-to-clear) and mask registers with a level
// output. A hardware event on the same edge as a clear of its bit wins.
// Assumes: the write strobes are already decoded from the host address.
module mgmt_irq_ctrl #(
    parameter int WIDTH   = 32,
    parameter int EVT_BIT = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic [WIDTH-1:0] wdata,
    input  logic             evt,
    output logic [WIDTH-1:0] status,
    output logic [WIDTH-1:0] mask,
    output logic             irq
);

    logic [WIDTH-1:0] stat_n;

    // Next status: clear the written ones, then merge the event.
    always_comb begin
        stat_n = status;
        if (wr_stat) stat_n = stat_n & ~wdata;
        if (evt)     stat_n[EVT_BIT] = 1'b1;
    end

    // Status and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
            mask   <= '0;
        end else begin
            status <= stat_n;
            if (wr_mask) mask <= wdata;
        end
    end

    // Level interrupt from the registered state.
    assign irq = |(status & mask);

    // R10: an event always leaves its status bit set
    a_r10_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> status[EVT_BIT]);

    // R10: clearing every set bit with no event drops the interrupt
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && ((status & ~wdata) == '0) && !evt) |=> !irq);

endmodule

// File: rtl/mgmt_phy_bridge.sv
// Module: mgmt_phy_bridge (top)
// Host register window onto an embedded PHY register model with link and
// auto-negotiation timing. A command write is executed on the following edge.
// Only PHY_ADDR responds; a read of another address returns all ones.
// Assumes: single-cycle host writes; reads are combinational.
module mgmt_phy_bridge
    import mgmt_pkg::*;
#(
    parameter int                PHY_ADDR = 1,
    parameter int                NUM_REGS = 6,
    parameter int                AN_DELAY = 50_000_000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               link_present,
    output logic               irq,
    output logic               link_up
);

    localparam logic [PHYA_W-1:0] MY_PHY = PHYA_W'(PHY_ADDR);

    logic [MII_W-1:0]   cmd_q;
    logic               pend_q;
    logic [HOST_DW-1:0] data_q;
    logic               wr_cmd, wr_dat, phy_hit, acc_en;
    logic [MII_W-1:0]   phy_rd;
    logic               an_en, an_cpl, ev_down, ev_set, ev_done;
    logic [HOST_DW-1:0] irq_stat, irq_mask;

    // Host write strobes and address match of the pending command.
    always_comb begin
        wr_cmd  = host_we && host_addr == W_MGMT_CMD;
        wr_dat  = host_we && host_addr == W_MGMT_DAT;
        phy_hit = cmd_q[CMD_PHY_LSB +: PHYA_W] == MY_PHY;
        acc_en  = pend_q && phy_hit;
    end

    // Command register and pending flag; busy clears when the access runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            pend_q <= 1'b0;
        end else if (wr_cmd) begin
            cmd_q  <= host_wdata[MII_W-1:0];
            pend_q <= 1'b1;
        end else if (pend_q) begin
            cmd_q[CMD_BUSY] <= 1'b0;
            pend_q          <= 1'b0;
        end
    end

    // Data register: host write, or the result of a management read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (pend_q && !cmd_q[CMD_WR_BIT]) begin
            data_q <= phy_hit ? {{(HOST_DW-MII_W){1'b0}}, phy_rd} : '1;
        end else if (wr_dat) begin
            data_q <= host_wdata;
        end
    end

    mgmt_phy_regs #(.NUM_REGS(NUM_REGS)) u_phy (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_wr     (cmd_q[CMD_WR_BIT]),
        .acc_idx    (cmd_q[IDX_W-1:0]),
        .acc_wdata  (data_q[MII_W-1:0]),
        .acc_rdata  (phy_rd),
        .ev_down    (ev_down),
        .ev_link_set(ev_set),
        .ev_an_done (ev_done),
        .an_enable  (an_en),
        .an_complete(an_cpl)
    );

    mgmt_link_ctrl #(.AN_DELAY(AN_DELAY)) u_link (
        .clk         (clk),
        .rst_n       (rst_n),
        .link_present(link_present),
        .an_enable   (an_en),
        .an_complete (an_cpl),
        .ev_down     (ev_down),
        .ev_link_set (ev_set),
        .ev_an_done  (ev_done),
        .link_up_o   (link_up)
    );

    mgmt_irq_ctrl #(.WIDTH(HOST_DW), .EVT_BIT(IRQ_LINK_BIT)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stat(host_we && host_addr == W_IRQ_STAT),
        .wr_mask(host_we && host_addr == W_IRQ_MASK),
        .wdata  (host_wdata),
        .evt    (ev_down || ev_set || ev_done),
        .status (irq_stat),
        .mask   (irq_mask),
        .irq    (irq)
    );

    // Host read mux; the MII status word always reads zero.
    always_comb begin
        case (host_addr)
            W_IRQ_STAT: host_rdata = irq_stat;
            W_IRQ_MASK: host_rdata = irq_mask;
            W_MII_STAT: host_rdata = '0;
            W_MGMT_CMD: host_rdata = {{(HOST_DW-MII_W){1'b0}}, cmd_q};
            W_MGMT_DAT: host_rdata = data_q;
            W_LINK_CTL: host_rdata = {{(HOST_DW-1){1'b0}}, link_up};
            default:    host_rdata = '0;
        endcase
    end

    // R3: busy is clear after an access that no new command overlaps
    a_r3_busy_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !wr_cmd) |=> !cmd_q[CMD_BUSY]);

    // R4: a read addressed to another PHY returns all ones
    a_r4_miss_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !cmd_q[CMD_WR_BIT] && !phy_hit) |=> (data_q == '1));

    // R11: the MII status word is always zero
    a_r11_mii_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == W_MII_STAT) |-> (host_rdata == '0));

endmodule

// File: tb/mgmt_phy_bridge_test.sv
module mgmt_phy_bridge_test;

    localparam int D = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        link_present = 1'b1;
    logic        irq, link_up;

    int checks = 0;
    int errors = 0;

    mgmt_phy_bridge #(.PHY_ADDR(1), .NUM_REGS(6), .AN_DELAY(D)) uut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .link_present(link_present), .irq(irq), .link_up(link_up)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic hwr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hrd(input logic [2:0] a, output logic [31:0] d);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    function automatic logic [31:0] mkcmd(input int phy, input int idx, input bit w);
        return 32'h8000 | (32'(w) << 10) | (32'(phy) << 5) | 32'(idx);
    endfunction

    task automatic mrd(input int phy, input int idx, output logic [31:0] d);
        hwr(3'd3, mkcmd(phy, idx, 1'b0));
        @(negedge clk);
        hrd(3'd4, d);
    endtask

    task automatic mwr(input int phy, input int idx, input logic [15:0] v);
        hwr(3'd4, {16'h0, v});
        hwr(3'd3, mkcmd(phy, idx, 1'b1));
        @(negedge clk);
    endtask

    // Reset value derived from the R1 field list.
    function automatic logic [15:0] rstval(input int idx);
        case (idx)
            0: return (16'd1 << 8) | (16'd1 << 12);
            1: return (16'd1 << 2) | (16'd1 << 3) | (16'd1 << 5);
            4, 5: begin
                logic [15:0] v = '0;
                for (int b = 5; b <= 9; b++) v[b] = 1'b1;
                return v;
            end
            default: return 16'h0;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 link_up", {31'h0, link_up}, 32'h1);
        hrd(3'd4, r); chk("R1 data", r, 32'h0);

        // R1/R5 sweep every index at the responding address
        for (int i = 0; i < 32; i++) begin
            mrd(1, i, r);
            chk(i < 6 ? "R1 reset reg" : "R5 high index read", r, i < 6 ? {16'h0, rstval(i)} : 32'h0);
        end

        // R4 sweep every PHY address, reading status
        for (int p = 0; p < 32; p++) begin
            mrd(p, 1, r);
            chk("R4 address match", r, p == 1 ? {16'h0, rstval(1)} : 32'hFFFF_FFFF);
        end

        // R2 write then read back; R3 busy timing
        hwr(3'd4, 32'h0000_1234);
        hwr(3'd3, mkcmd(1, 4, 1'b1));
        hrd(3'd3, r); chk("R3 busy before access", r[15], 1'b1);
        @(negedge clk);
        hrd(3'd3, r); chk("R3 busy after access", r[15], 1'b0);
        mrd(1, 4, r); chk("R2 write readback", r, 32'h1234);
        for (int v = 0; v < 4; v++) begin
            mwr(1, 3, 16'(16'hA5A5 ^ (v * 16'h1111)));
            mrd(1, 3, r); chk("R2 write pattern", r, {16'h0, 16'(16'hA5A5 ^ (v * 16'h1111))});
        end

        // R4 write to another PHY ignored
        mwr(2, 4, 16'hBEEF);
        mrd(1, 4, r); chk("R4 miss write ignored", r, 32'h1234);
        // R5 write to high index ignored
        mwr(1, 7, 16'hCAFE);
        mrd(1, 7, r); chk("R5 high write ignored", r, 32'h0);

        // R11 MII status word reads zero, write has no effect
        hwr(3'd2, 32'hFFFF_FFFF);
        hrd(3'd2, r); chk("R11 mii status zero", r, 32'h0);
        hrd(3'd0, r); chk("R11 no irq side effect", r, 32'h0);

        // R6 link loss
        @(negedge clk); link_present = 1'b0;
        @(negedge clk);
        chk("R6 link_up low", {31'h0, link_up}, 32'h0);
        hrd(3'd0, r); chk("R6 irq status bit4", r, 32'h10);
        chk("R10 masked irq low", {31'h0, irq}, 32'h0);
        mrd(1, 1, r); chk("R6 status cleared", r, 32'h0008);
        mrd(1, 5, r); chk("R6 partner ack clear", r, {16'h0, rstval(5)});

        // R10 mask re-evaluation and write-one-to-clear
        hwr(3'd1, 32'h10);
        chk("R10 irq after mask", {31'h0, irq}, 32'h1);
        hwr(3'd0, 32'h01);
        chk("R10 wrong bit keeps irq", {31'h0, irq}, 32'h1);
        hwr(3'd0, 32'h10);
        chk("R10 irq after clear", {31'h0, irq}, 32'h0);

        // R7 timed negotiation: 0 after D edges, 1 after D+1
        @(negedge clk); link_present = 1'b1;
        repeat (D) @(negedge clk);
        chk("R7 not yet up", {31'h0, link_up}, 32'h0);
        chk("R7 no irq yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 up at expiry", {31'h0, link_up}, 32'h1);
        chk("R7 irq at expiry", {31'h0, irq}, 32'h1);
        mrd(1, 1, r); chk("R7 status", r, {16'h0, rstval(1)});
        mrd(1, 5, r); chk("R7 partner ack", r, {16'h0, rstval(5) | 16'h4000});
        hwr(3'd0, 32'h10);

        // R9 link loss during countdown cancels
        @(negedge clk); link_present = 1'b0;
        @(negedge clk); link_present = 1'b1;
        repeat (D / 2) @(negedge clk);
        link_present = 1'b0;
        repeat (2 * D) @(negedge clk);
        chk("R9 stays down", {31'h0, link_up}, 32'h0);
        hrd(3'd5, r); chk("R9 link word", r, 32'h0);
        mrd(1, 1, r); chk("R9 status", r, 32'h0008);

        // R8 immediate link-up with negotiation disabled
        mwr(1, 0, 16'h0100);
        hwr(3'd0, 32'h10);
        @(negedge clk); link_present = 1'b1;
        @(negedge clk);
        chk("R8 immediate up", {31'h0, link_up}, 32'h1);
        hrd(3'd0, r); chk("R8 irq status", r, 32'h10);
        mrd(1, 1, r); chk("R8 status link only", r, 32'h000C);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule